// File: doc/BRIEF.md
# Double-Rate Word Width Memory Adapter

This adapter lets a core with a 32-bit data port use a memory whose data path is only 16 bits wide. It runs on a clock at twice the core frequency. Each core cycle therefore contains two fast cycles. The adapter uses those two fast cycles to make two 16-bit memory accesses, so a full 32-bit read or write finishes inside one core cycle and the core never stalls.

An internal phase flag marks which fast cycle is in progress. The first fast cycle follows the core's rising edge and the second follows its falling edge. The phase flag is brought out so the system can derive the core clock from it. The low halfword always moves first, at the even memory address. The high halfword follows at the next odd address. On a read, the low half is parked in a holding register and merged with the high half at the fast edge that is also the core's next rising edge. The merged word then stays fixed for the whole of the following core cycle.

The memory is expected to return read data within the same fast cycle as its address, and to commit writes on the fast clock edge. The core holds its request inputs steady for a full core cycle, starting at the fast edge that begins phase 0.

Top module: `dual_rate_mem_adapter`

## Requirements
- R1: While `rst` is high, `phase_o` is 0, `cpu_rdata` is 0, and `mem_en` and `mem_we` are 0 whatever the request inputs are. Reset is synchronous and active-high.
- R2: After reset is released, `phase_o` toggles on every rising edge of `clk_2x`. The fast cycle in which reset drops is a phase-0 cycle.
- R3: During a request, `mem_addr` is `{cpu_addr, 1'b0}` while `phase_o` is 0 and `{cpu_addr, 1'b1}` while `phase_o` is 1. `mem_en` is 1 in both fast cycles.
- R4: During a write (`cpu_we`=1), `mem_we` is 1 in both fast cycles. `mem_wdata` carries `cpu_wdata[15:0]` in phase 0 and `cpu_wdata[31:16]` in phase 1.
- R5: During a read, `cpu_rdata` becomes `{halfword at 2A+1, halfword at 2A}` at the `clk_2x` rising edge that ends the phase-1 cycle.
- R6: `cpu_rdata` changes only at that edge after a read. It is unchanged across both fast cycles of the next core cycle and across write and idle cycles.
- R7: When `cpu_req` is 0, `mem_en` and `mem_we` are 0 in both phases.
- R8: During a read, `mem_we` is 0 in both phases.
- R9: A word written at any address, including address 0 and the top address, reads back unchanged with its halfwords in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2x | input | 1 | Fast clock at twice the core frequency |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Core requests an access this core cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Core word address |
| cpu_wdata | input | WORD_W | Word to be written |
| cpu_rdata | output | WORD_W | Assembled read word, registered |
| phase_o | output | 1 | 0 in the first fast cycle of a core cycle, 1 in the second |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W+1 | Halfword address |
| mem_wdata | output | WORD_W/2 | Halfword to be written |
| mem_rdata | input | WORD_W/2 | Halfword read from memory |

## Verification
The bench targets halfword ordering. Distinct upper and lower halves are written and read back, and the memory cells are also inspected directly, so a swapped order shows up as exchanged halves or as a wrong cell. It probes address 0 and the top address, where a faulty address shift would wrap or lose the odd bit. It samples `cpu_rdata` in both fast cycles and across write and idle cycles, which catches a design that updates the word at the wrong edge or lets write traffic disturb it. Idle cycles with a request pending during reset catch enables that leak out when no access is wanted.

// File: rtl/dra_pkg.sv
package dra_pkg;
  // Which halfword the adapter is moving in the current fast cycle.
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/dra_phase.sv
module dra_phase
  import dra_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output half_e phase
);
  // Flips on every fast edge; phase 0 starts each core cycle.
  always_ff @(posedge clk) begin
    if (rst) phase <= HALF_LO;
    else     phase <= (phase == HALF_LO) ? HALF_HI : HALF_LO;
  end
endmodule

// File: rtl/dra_split.sv
module dra_split
  import dra_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 32,
  localparam int HALF_W = WORD_W / 2,
  localparam int MEM_AW = ADDR_W + 1
) (
  input  logic              rst,
  input  half_e             phase,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [HALF_W-1:0] mem_wdata
);
  logic active;

  assign active = req & ~rst;

  always_comb begin
    mem_en   = active;
    mem_we   = active & we;
    // The odd halfword address carries the upper half of the word.
    mem_addr = {addr, phase == HALF_HI};
    if (phase == HALF_HI) mem_wdata = wdata[WORD_W-1:HALF_W];
    else                  mem_wdata = wdata[HALF_W-1:0];
  end
endmodule

// File: rtl/dra_gather.sv
module dra_gather
  import dra_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int HALF_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  half_e             phase,
  input  logic              rd_fire,
  input  logic [HALF_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] word_q
);
  logic [HALF_W-1:0] lo_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_hold <= '0;
      word_q  <= '0;
    end else if (rd_fire) begin
      if (phase == HALF_LO) lo_hold <= mem_rdata;
      else                  word_q  <= {mem_rdata, lo_hold};
    end
  end
endmodule

// File: rtl/dual_rate_mem_adapter.sv
module dual_rate_mem_adapter
  import dra_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 32,
  localparam int HALF_W = WORD_W / 2,
  localparam int MEM_AW = ADDR_W + 1
) (
  input  logic              clk_2x,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              phase_o,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [HALF_W-1:0] mem_wdata,
  input  logic [HALF_W-1:0] mem_rdata
);
  half_e phase;
  logic  rd_fire;

  assign rd_fire = cpu_req & ~cpu_we;
  assign phase_o = (phase == HALF_HI);

  dra_phase u_phase (
    .clk   (clk_2x),
    .rst   (rst),
    .phase (phase)
  );

  dra_split #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_split (
    .rst       (rst),
    .phase     (phase),
    .req       (cpu_req),
    .we        (cpu_we),
    .addr      (cpu_addr),
    .wdata     (cpu_wdata),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  dra_gather #(.WORD_W(WORD_W)) u_gather (
    .clk       (clk_2x),
    .rst       (rst),
    .phase     (phase),
    .rd_fire   (rd_fire),
    .mem_rdata (mem_rdata),
    .word_q    (cpu_rdata)
  );
endmodule

// File: rtl/dra_checker.sv
module dra_checker #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 32,
  localparam int HALF_W = WORD_W / 2,
  localparam int MEM_AW = ADDR_W + 1
) (
  input logic              clk_2x,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [WORD_W-1:0] cpu_wdata,
  input logic [WORD_W-1:0] cpu_rdata,
  input logic              phase_o,
  input logic              mem_en,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [HALF_W-1:0] mem_wdata
);
  AST_RESET_QUIET: assert property (@(posedge clk_2x)
    rst |-> (!mem_en && !mem_we)); // R1

  AST_PHASE_TOGGLE: assert property (@(posedge clk_2x) disable iff (rst)
    1'b1 |=> (phase_o != $past(phase_o))); // R2

  AST_ADDR_PARITY: assert property (@(posedge clk_2x) disable iff (rst)
    mem_en |-> (mem_addr[0] == phase_o)); // R3

  AST_ADDR_WORD: assert property (@(posedge clk_2x) disable iff (rst)
    mem_en |-> (mem_addr[MEM_AW-1:1] == cpu_addr)); // R3

  AST_WDATA_LO: assert property (@(posedge clk_2x) disable iff (rst)
    (mem_we && !phase_o) |-> (mem_wdata == cpu_wdata[HALF_W-1:0])); // R4

  AST_WDATA_HI: assert property (@(posedge clk_2x) disable iff (rst)
    (mem_we && phase_o) |-> (mem_wdata == cpu_wdata[WORD_W-1:HALF_W])); // R4

  AST_RDATA_STEADY: assert property (@(posedge clk_2x) disable iff (rst)
    phase_o |-> $stable(cpu_rdata)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk_2x) disable iff (rst)
    !cpu_req |-> (!mem_en && !mem_we)); // R7

  AST_READ_NO_WRITE: assert property (@(posedge clk_2x) disable iff (rst)
    (cpu_req && !cpu_we) |-> !mem_we); // R8
endmodule

bind dual_rate_mem_adapter dra_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk_2x    (clk_2x),
  .rst       (rst),
  .cpu_req   (cpu_req),
  .cpu_we    (cpu_we),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_rdata (cpu_rdata),
  .phase_o   (phase_o),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata)
);

// File: tb/dual_rate_mem_adapter_tb_top.sv
`timescale 1ns/1ps
module dual_rate_mem_adapter_tb_top;
  localparam int AW = 6;
  localparam int WW = 32;
  localparam int HW = WW / 2;
  localparam int MD = 2 ** (AW + 1);
  localparam int NV = 9;

  // Vector layout: {we, addr[5:0], wdata[31:0], expected cpu_rdata[31:0]}
  localparam logic [70:0] VEC [NV] = '{
    {1'b1, 6'd1,  32'h1234_5678, 32'h0000_0000},
    {1'b1, 6'd2,  32'hDEAD_BEEF, 32'h0000_0000},
    {1'b0, 6'd1,  32'h0000_0000, 32'h1234_5678},
    {1'b0, 6'd2,  32'h0000_0000, 32'hDEAD_BEEF},
    {1'b1, 6'd63, 32'hFFFF_0000, 32'hDEAD_BEEF},
    {1'b0, 6'd63, 32'h0000_0000, 32'hFFFF_0000},
    {1'b0, 6'd0,  32'h0000_0000, 32'h0000_0000},
    {1'b1, 6'd0,  32'h0001_FFFE, 32'h0000_0000},
    {1'b0, 6'd0,  32'h0000_0000, 32'h0001_FFFE}
  };

  logic          clk_2x = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_req = 1'b0;
  logic          cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [WW-1:0] cpu_wdata = '0;
  logic [WW-1:0] cpu_rdata;
  logic          phase_o;
  logic          mem_en;
  logic          mem_we;
  logic [AW:0]   mem_addr;
  logic [HW-1:0] mem_wdata;
  logic [HW-1:0] mem_rdata;
  logic [HW-1:0] mem [MD];

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk_2x = ~clk_2x;

  dual_rate_mem_adapter #(.ADDR_W(AW), .WORD_W(WW)) dut_i (
    .clk_2x    (clk_2x),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .phase_o   (phase_o),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  // Halfword memory: same-cycle read, write on the fast edge.
  assign mem_rdata = mem[mem_addr];
  always_ff @(posedge clk_2x) begin
    if (rst) begin
      for (int i = 0; i < MD; i++) mem[i] <= '0;
    end else if (mem_en && mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
  end

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Called at a falling edge inside a phase-0 cycle; returns at the
  // falling edge inside the next phase-0 cycle.
  task automatic core_cycle(input logic req, input logic we,
                            input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] held;
    cpu_req = req; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1;
    held = cpu_rdata;
    check(phase_o == 1'b0, "R2", 32'(phase_o), 32'd0);
    if (req) begin
      check(mem_en == 1'b1, "R3", 32'(mem_en), 32'd1);
      check(mem_addr == {a, 1'b0}, "R3", 32'(mem_addr), 32'({a, 1'b0}));
      check(mem_we == we, we ? "R4" : "R8", 32'(mem_we), 32'(we));
      if (we) check(mem_wdata == d[15:0], "R4", 32'(mem_wdata), 32'(d[15:0]));
    end else begin
      check(!mem_en && !mem_we, "R7", 32'({mem_en, mem_we}), 32'd0);
    end
    @(posedge clk_2x); @(negedge clk_2x);
    check(phase_o == 1'b1, "R2", 32'(phase_o), 32'd1);
    check(cpu_rdata == held, "R6", cpu_rdata, held);
    if (req) begin
      check(mem_en == 1'b1, "R3", 32'(mem_en), 32'd1);
      check(mem_addr == {a, 1'b1}, "R3", 32'(mem_addr), 32'({a, 1'b1}));
      check(mem_we == we, we ? "R4" : "R8", 32'(mem_we), 32'(we));
      if (we) check(mem_wdata == d[31:16], "R4", 32'(mem_wdata), 32'(d[31:16]));
    end else begin
      check(!mem_en && !mem_we, "R7", 32'({mem_en, mem_we}), 32'd0);
    end
    @(posedge clk_2x); @(negedge clk_2x);
  endtask

  initial begin
    repeat (200000) @(posedge clk_2x);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [70:0] v;
    // R1: a pending request must not reach the memory during reset.
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 6'd5; cpu_wdata = 32'hCAFE_F00D;
    repeat (4) @(negedge clk_2x);
    check(phase_o == 1'b0, "R1", 32'(phase_o), 32'd0);
    check(cpu_rdata == 32'd0, "R1", cpu_rdata, 32'd0);
    check(!mem_en && !mem_we, "R1", 32'({mem_en, mem_we}), 32'd0);
    @(negedge clk_2x);
    check(mem[10] == 16'h0 && mem[11] == 16'h0, "R1", 32'({mem[11], mem[10]}), 32'd0);
    rst = 1'b0;
    cpu_req = 1'b0;

    // Table walk: R3, R4, R5, R6, R8 and R9 (addresses 0 and 63 are the ends).
    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      core_cycle(1'b1, v[70], v[69:64], v[63:32]);
      check(cpu_rdata == v[31:0], v[70] ? "R6" : "R5/R9", cpu_rdata, v[31:0]);
    end

    // R3 ordering at the cells: low half at the even address.
    check({mem[3], mem[2]} == 32'h1234_5678, "R3", 32'({mem[3], mem[2]}), 32'h1234_5678);
    check({mem[127], mem[126]} == 32'hFFFF_0000, "R9", 32'({mem[127], mem[126]}),
          32'hFFFF_0000);

    // R7: idle cycles keep memory quiet and R6 the held word.
    core_cycle(1'b0, 1'b1, 6'd2, 32'h5555_AAAA);
    check(cpu_rdata == 32'h0001_FFFE, "R6", cpu_rdata, 32'h0001_FFFE);
    check({mem[5], mem[4]} == 32'hDEAD_BEEF, "R7", 32'({mem[5], mem[4]}), 32'hDEAD_BEEF);
    core_cycle(1'b0, 1'b0, 6'd1, 32'h0);
    check(cpu_rdata == 32'h0001_FFFE, "R6", cpu_rdata, 32'h0001_FFFE);

    // Back-to-back reads of different words: R5.
    core_cycle(1'b1, 1'b0, 6'd63, 32'h0);
    check(cpu_rdata == 32'hFFFF_0000, "R5", cpu_rdata, 32'hFFFF_0000);
    core_cycle(1'b1, 1'b0, 6'd1, 32'h0);
    check(cpu_rdata == 32'h1234_5678, "R5", cpu_rdata, 32'h1234_5678);

    // Overwrite then read back: R9.
    core_cycle(1'b1, 1'b1, 6'd1, 32'h8001_7FFE);
    check(cpu_rdata == 32'h1234_5678, "R6", cpu_rdata, 32'h1234_5678);
    core_cycle(1'b1, 1'b0, 6'd1, 32'h0);
    check(cpu_rdata == 32'h8001_7FFE, "R9", cpu_rdata, 32'h8001_7FFE);

    // Reset in mid-run clears the output word: R1.
    rst = 1'b1;
    @(negedge clk_2x); @(negedge clk_2x);
    check(cpu_rdata == 32'd0, "R1", cpu_rdata, 32'd0);
    check(phase_o == 1'b0, "R1", 32'(phase_o), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule